// File: doc/BRIEF.md
# Serial Long-Division CRC-4 Engine

This block computes a 4-bit cyclic redundancy remainder with the shift-and-subtract method of mod-2 long division. A parallel load takes a message word and a 4-bit generator. The generator holds the divisor without its leading one, which is always present. A start pulse then moves one bit per clock through a single left-shifting chain. From the top, the chain holds a one-bit overflow stage, the 4-bit remainder register, the message register and a 4-bit pad of zeros. After each shift, the bit that has just reached the overflow stage selects one of two table entries, either all zeros or the generator. That entry is XORed into the remainder register in the same clock edge as the shift.

Appending the four zero bits yields the remainder of the message multiplied by x^4. Once every message bit and every pad bit has passed into the remainder register, the engine raises a one-cycle done flag. The result then stays on the output until the next load. A new load must come before each start. Loads and starts that arrive during a computation are dropped.

Top module: `crc4_long_div`

## Requirements
- R1: After reset, `done` is 0 and `remainder` is 0000.
- R2: A load accepted while no computation is running captures `msgIn` and `genIn` and clears the remainder, so `remainder` reads 0000 in the cycle after the load edge.
- R3: The remainder reported with `done` equals the mod-2 remainder of the message followed by four zero bits, divided by the 5-bit divisor {1, genIn}. The message is taken most significant bit first.
- R4: For message 10101101 with generator 1001, the reported remainder is 1001.
- R5: `done` is high for exactly one cycle. It rises at the MSG_W+4-th rising edge after the edge that accepts start, which is 12 edges at the default width.
- R6: A load during a computation is ignored, and the result belongs to the message loaded before start.
- R7: A start pulse during a computation is ignored: only one `done` follows, on the original schedule.
- R8: After `done`, `remainder` holds its value until the next accepted load.
- R9: The generator is captured at load, and a change on `genIn` after the load has no effect on the result.
- R10: A start with no fresh load since the last start is ignored: no `done` follows and `remainder` does not change. A start in the same cycle as a load is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| loadIn | input | 1 | Parallel load strobe for message and generator |
| startIn | input | 1 | Start pulse, begins MSG_W+4 shifts |
| msgIn | input | MSG_W | Message word, MSB is shifted first |
| genIn | input | 4 | Divisor bits below the implicit leading one |
| done | output | 1 | One-cycle flag, remainder valid |
| remainder | output | 4 | Current remainder register |

## Verification
A wrong bit in the remainder register, the overflow stage or the table selection changes the division for every message bit that follows it. It therefore appears as a mismatched remainder at the `done` pulse, at most MSG_W+4 cycles after the fault. A shift counter that is off by one moves `done` by a cycle. It also feeds one pad bit more or less into the remainder, so both the latency check and the value check catch it. A fault in the load gating or the arming logic shows up at once: either a nonzero remainder right after a load, or an extra or missing `done`.

// File: rtl/crc_aug_pkg.sv
package crc_aug_pkg;
  localparam int CRC_W = 4;
  localparam int PAD_W = CRC_W;

  typedef struct packed {
    logic loadStb;
    logic shiftStb;
  } ctrlStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } ctrlState_t;
endpackage

// File: rtl/crc_aug_ctrl.sv
module crc_aug_ctrl
  import crc_aug_pkg::*;
#(
  parameter int MSG_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadIn,
  input  logic      startIn,
  output ctrlStrb_t strb,
  output logic      done
);
  localparam int SHIFTS = MSG_W + PAD_W;
  localparam int CNT_W  = $clog2(SHIFTS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SHIFTS - 1);

  ctrlState_t stateQ, stateN;
  logic [CNT_W-1:0] cntQ, cntN;
  logic doneN;

  // strobes towards the datapath
  always_comb begin
    strb.loadStb  = loadIn && (stateQ != ST_RUN);
    strb.shiftStb = (stateQ == ST_RUN);
  end

  always_comb begin
    stateN = stateQ;
    cntN   = cntQ;
    doneN  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (loadIn) stateN = ST_ARMED;
      end
      ST_ARMED: begin
        if (!loadIn && startIn) begin
          stateN = ST_RUN;
          cntN   = '0;
        end
      end
      ST_RUN: begin
        if (cntQ == LAST_CNT) begin
          stateN = ST_IDLE;
          doneN  = 1'b1;
        end else begin
          cntN = cntQ + 1'b1;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      done   <= 1'b0;
    end else begin
      stateQ <= stateN;
      cntQ   <= cntN;
      done   <= doneN;
    end
  end
endmodule

// File: rtl/crc_aug_dpath.sv
module crc_aug_dpath
  import crc_aug_pkg::*;
#(
  parameter int MSG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [MSG_W-1:0] msgIn,
  input  logic [CRC_W-1:0] genIn,
  output logic [CRC_W-1:0] remainder
);
  localparam int CHAIN_W = 1 + CRC_W + MSG_W + PAD_W;
  localparam int TBL_N   = 2;

  logic             ovfQ;
  logic [CRC_W-1:0] crcQ;
  logic [MSG_W-1:0] msgQ;
  logic [PAD_W-1:0] padQ;
  logic [CRC_W-1:0] genQ;

  logic [CRC_W-1:0] tbl [TBL_N];

  // entry 0 is all zeros, entry 1 the captured generator
  for (genvar e = 0; e < TBL_N; e++) begin : g_tbl
    if (e == 0) begin : g_zero
      assign tbl[e] = '0;
    end else begin : g_gen
      assign tbl[e] = genQ;
    end
  end

  logic [CHAIN_W-1:0] chainCur, chainSh;
  logic               shOvf;
  logic [CRC_W-1:0]   shCrc;
  logic [MSG_W-1:0]   shMsg;
  logic [PAD_W-1:0]   shPad;
  logic [CRC_W-1:0]   crcNext;

  always_comb begin
    chainCur = {ovfQ, crcQ, msgQ, padQ};
    chainSh  = chainCur << 1;
    {shOvf, shCrc, shMsg, shPad} = chainSh;
    crcNext  = shCrc ^ tbl[shOvf];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfQ <= 1'b0;
      crcQ <= '0;
      msgQ <= '0;
      padQ <= '0;
      genQ <= '0;
    end else if (strb.loadStb) begin
      ovfQ <= 1'b0;
      crcQ <= '0;
      msgQ <= msgIn;
      padQ <= '0;
      genQ <= genIn;
    end else if (strb.shiftStb) begin
      ovfQ <= shOvf;
      crcQ <= crcNext;
      msgQ <= shMsg;
      padQ <= shPad;
    end
  end

  assign remainder = crcQ;
endmodule

// File: rtl/crc4_long_div.sv
module crc4_long_div
  import crc_aug_pkg::*;
#(
  parameter int MSG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadIn,
  input  logic             startIn,
  input  logic [MSG_W-1:0] msgIn,
  input  logic [3:0]       genIn,
  output logic             done,
  output logic [3:0]       remainder
);
  ctrlStrb_t ctrlStrb;
  logic      loadAcc;
  logic      shiftEn;

  crc_aug_ctrl #(.MSG_W(MSG_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadIn  (loadIn),
    .startIn (startIn),
    .strb    (ctrlStrb),
    .done    (done)
  );

  crc_aug_dpath #(.MSG_W(MSG_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (ctrlStrb),
    .msgIn     (msgIn),
    .genIn     (genIn),
    .remainder (remainder)
  );

  assign loadAcc = ctrlStrb.loadStb;
  assign shiftEn = ctrlStrb.shiftStb;
endmodule

// File: rtl/crc4_long_div_chk.sv
module crc4_long_div_chk #(
  parameter int MSG_W = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       loadIn,
  input logic       done,
  input logic [3:0] remainder,
  input logic       loadAcc,
  input logic       shiftEn
);
  localparam int SHIFTS = MSG_W + 4;
  localparam int CNT_W  = $clog2(SHIFTS + 2);

  logic [CNT_W-1:0] shiftCnt;
  logic             holdFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftCnt <= '0;
      holdFlag <= 1'b0;
    end else begin
      if (loadAcc) shiftCnt <= '0;
      else if (shiftEn && shiftCnt != CNT_W'(SHIFTS + 1)) shiftCnt <= shiftCnt + 1'b1;
      if (loadAcc) holdFlag <= 1'b0;
      else if (done) holdFlag <= 1'b1;
    end
  end

  // R5: done lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: done only after exactly MSG_W+4 shifts since the load
  a_r5_shift_count: assert property (@(posedge clk) disable iff (!rstN)
    done |-> shiftCnt == CNT_W'(SHIFTS));

  // R2: an accepted load clears the remainder
  a_r2_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    loadAcc |=> remainder == 4'd0);

  // R8: result held after done until a new load
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done || holdFlag) && !loadIn |=> $stable(remainder));

  // R6: no load accepted while shifting
  a_r6_no_load_in_run: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |-> !loadAcc);
endmodule

bind crc4_long_div crc4_long_div_chk #(.MSG_W(MSG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loadIn    (loadIn),
  .done      (done),
  .remainder (remainder),
  .loadAcc   (loadAcc),
  .shiftEn   (shiftEn)
);

// File: tb/tb_crc4_long_div.sv
`timescale 1ns/1ps
module tb_crc4_long_div;
  localparam int MSG_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             loadIn = 1'b0;
  logic             startIn = 1'b0;
  logic [MSG_W-1:0] msgIn = '0;
  logic [3:0]       genIn = '0;
  logic             done;
  logic [3:0]       remainder;

  int checks = 0;
  int fails = 0;
  logic [3:0] expQ[$];
  string      tagQ[$];
  logic       prevDone = 1'b0;

  always #5 clk = ~clk;

  crc4_long_div #(.MSG_W(MSG_W)) dut (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .startIn(startIn),
    .msgIn(msgIn), .genIn(genIn), .done(done), .remainder(remainder)
  );

  function automatic logic [3:0] refRem(input logic [MSG_W-1:0] m, input logic [3:0] g);
    logic [4:0] r;
    r = '0;
    for (int i = MSG_W + 3; i >= 0; i--) begin
      r = {r[3:0], (i >= 4) ? m[i-4] : 1'b0};
      if (r[4]) r = r ^ {1'b1, g};
    end
    return r[3:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected results when done is seen, checks one-cycle width
  always @(negedge clk) begin
    if (rstN) begin
      if (done && prevDone) check(1'b0, "R5 done width", 1, 0);
      if (done) begin
        if (expQ.size() == 0) check(1'b0, "R7/R10 unexpected done", 1, 0);
        else begin
          automatic logic [3:0] e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          check(remainder == e, t, remainder, e);
        end
      end
      prevDone <= done;
    end
  end

  // driver: load, start, optional disturbances, latency check
  task automatic runJob(input logic [MSG_W-1:0] m, input logic [3:0] g,
                        input string tag, input bit midLoad, input bit midStart,
                        input bit genSwap);
    int cyc;
    @(posedge clk); #1;
    msgIn = m; genIn = g; loadIn = 1'b1;
    @(posedge clk); #1;
    loadIn = 1'b0;
    check(remainder == 4'd0, "R2 cleared on load", remainder, 0);
    expQ.push_back(refRem(m, g));
    tagQ.push_back(tag);
    if (genSwap) genIn = ~g;
    startIn = 1'b1;
    @(posedge clk); #1;
    startIn = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(posedge clk); #1;
      cyc++;
      if (midLoad && cyc == 3) begin loadIn = 1'b1; msgIn = ~m; genIn = g ^ 4'b0110; end
      if (midStart && cyc == 3) startIn = 1'b1;
      if (cyc == 4) begin loadIn = 1'b0; startIn = 1'b0; end
    end
    check(cyc == MSG_W + 4, "R5 latency", cyc, MSG_W + 4);
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] held;
    int seenDone;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done reset", done, 0);
    check(remainder == 4'd0, "R1 remainder reset", remainder, 0);

    // R4: worked example, expected value written out
    runJob(8'b10101101, 4'b1001, "R4 example", 0, 0, 0);
    check(remainder == 4'b1001, "R4 example value", remainder, 4'b1001);

    // R3: assorted patterns
    runJob(8'h00, 4'b1001, "R3 zero msg", 0, 0, 0);
    runJob(8'hFF, 4'b0011, "R3 all ones", 0, 0, 0);
    runJob(8'h80, 4'b0111, "R3 single msb", 0, 0, 0);
    runJob(8'h01, 4'b0000, "R3 gen zero", 0, 0, 0);
    for (int k = 0; k < 8; k++)
      runJob(8'(k * 37 + 11), 4'(k * 5 + 3), "R3 sweep", 0, 0, 0);

    // R6: load mid-run ignored
    runJob(8'h5A, 4'b1101, "R6 load in run", 1, 0, 0);
    // R7: start mid-run ignored
    runJob(8'hC3, 4'b1011, "R7 start in run", 0, 1, 0);
    // R9: genIn change after load
    runJob(8'h96, 4'b0101, "R9 gen captured", 0, 0, 1);

    // R8 and R10: hold, and unarmed start ignored
    held = remainder;
    seenDone = 0;
    @(posedge clk); #1 startIn = 1'b1;
    @(posedge clk); #1 startIn = 1'b0;
    for (int k = 0; k < MSG_W + 8; k++) begin
      @(posedge clk); #1;
      if (done) seenDone++;
    end
    check(seenDone == 0, "R10 unarmed start", seenDone, 0);
    check(remainder == held, "R8 result held", remainder, held);

    // R10: start in the same cycle as load ignored
    msgIn = 8'hA5; genIn = 4'b1001; loadIn = 1'b1; startIn = 1'b1;
    @(posedge clk); #1 loadIn = 1'b0; startIn = 1'b0;
    seenDone = 0;
    for (int k = 0; k < MSG_W + 8; k++) begin
      @(posedge clk); #1;
      if (done) seenDone++;
    end
    check(seenDone == 0, "R10 start with load", seenDone, 0);
    check(remainder == 4'd0, "R10 remainder stays cleared", remainder, 0);

    check(expQ.size() == 0, "R7 scoreboard drained", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule